// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block is the register unit that a downstream port uses to manage a hot-plug slot. It keeps a 16-bit slot control word and a 16-bit slot status word, both reached through a simple register port with a write strobe, a 2-bit register select and a combinational read path. The control word sets the attention and power indicators, switches slot power and holds the enables for interrupts. The status word latches slot events from debounced, synchronous inputs: attention button, latch sensor, card presence, power fault and link state. It also reports the live latch and presence levels.

Software clears status flags by writing ones to them. Every write to the control word starts a programmable delay, and when it runs out the command-completed flag is set. Ports with no power controller, no indicators and no interlock do not report completion. A third register drives a link-disable output and shows the link-active input. The interrupt request is a level. It stays high while the global hot-plug enable is set and at least one flag whose own enable is set remains uncleared. Blink is given as an enable output; the oscillator that makes the blink sits outside the block.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset the control word (select 0) reads 0x07C0 and the status flags read 0. All indicator outputs, slot power, link disable and the interrupt are low.
- R2: Control bits 7:6 drive the attention indicator: 01 lit steady, 10 lit and blinking, 11 dark. The value 00 is reserved and also gives dark.
- R3: Control bits 9:8 drive the power indicator with the same encoding as R2.
- R4: Control bit 10 switches slot power: 0 applies power (slot_pwr_o high) and 1 removes it.
- R5: Status bit 0 sets on a rising edge of the button input, bit 2 on any change of the latch sensor, bit 3 on any change of presence, and bit 8 on any change of link-active. Each flag is visible one cycle after the input change. Bits 5 and 6 read the live latch and presence levels. A button held high sets bit 0 only once.
- R6: Writing the status word (select 1) clears exactly the flags written as one. A value of 0x1F clears bits 0 to 4, and writing zero changes nothing. An event in the same cycle as its clear leaves the flag set.
- R7: Status bit 1 (power fault) is set in every cycle that the fault input is high, so clearing it while the fault stays present has no effect.
- R8: Status bit 4 sets exactly CC_DELAY cycles after each write to the control word. A new write while a command is pending restarts the delay.
- R9: irq_o is high exactly when control bit 5 is set and some flag is set together with its enable. The enables map as follows: control bits 0 to 4 enable status bits 0 to 4, and control bit 12 enables status bit 8.
- R10: Select 2 holds the link register. Bit 4 is writable and drives link_dis_o, and bit 13 reads the link-active input.
- R11: With no power controller, no indicators and no interlock (parameters all zero), status bit 4 is never set.
- R12: Control bits 11 and 15:13 are reserved; they ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 link |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_sel |
| btn_i | input | 1 | Debounced attention button |
| mrl_i | input | 1 | Debounced latch sensor level |
| prsnt_i | input | 1 | Debounced card presence level |
| pfault_i | input | 1 | Power fault level |
| link_up_i | input | 1 | Data-link-layer link active |
| attn_led_o | output | 1 | Attention indicator lit |
| attn_blink_o | output | 1 | Attention indicator blink enable |
| pwr_led_o | output | 1 | Power indicator lit |
| pwr_blink_o | output | 1 | Power indicator blink enable |
| slot_pwr_o | output | 1 | Slot power applied |
| link_dis_o | output | 1 | Link disable request |
| irq_o | output | 1 | Level interrupt request |

## Verification
The indicator and power decode is run through a table that covers all four codes of each 2-bit field, with power both on and off. This separates a swapped field or code from a correct one. The event flags are exercised one input at a time, then together with clears of one bit, of zero and of all five. This shows whether a clear reaches flags it should not touch. A clear that coincides with a new event, and a fault that is still present, show whether a flag can be lost or wrongly dropped. Completion is sampled one cycle before and exactly at the delay, both for a single write and for a restarted one, and a second instance with no capabilities shows that reporting is suppressed.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_LINK = 2'd2;

    localparam logic [15:0] CTRL_RESET = 16'h07C0;
    localparam logic [15:0] CTRL_WMASK = 16'h17FF;

    localparam int B_HPIE     = 5;
    localparam int B_PWR_OFF  = 10;
    localparam int B_LINK_EN  = 12;
    localparam int B_LINK_DIS = 4;
    localparam int B_LINK_UP  = 13;

    localparam int NFLAG = 6;

    typedef struct packed {
        logic       prev_btn;
        logic       prev_mrl;
        logic       prev_prs;
        logic       prev_link;
        logic [NFLAG-1:0] ev;
    } ev_state_t;

    typedef struct packed {
        logic [15:0] ctrl;
        logic        link_dis;
    } ctrl_state_t;

    typedef struct packed {
        logic lit;
        logic blink;
    } ind_t;

    function automatic ind_t decode_ind(input logic [1:0] code);
        ind_t r;
        r.lit   = (code == 2'b01) || (code == 2'b10);
        r.blink = (code == 2'b10);
        return r;
    endfunction

endpackage

// File: rtl/hp_cmd_timer.sv
module hp_cmd_timer #(
    parameter int unsigned DELAY  = 125000,
    parameter bit          ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(DELAY + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_q, s_d;
    logic fire;

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(DELAY);
        end else if (s_q.busy) begin
            if (s_q.cnt <= CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                fire     = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = ENABLE && fire;

    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> s_q.busy);

    p_cnt_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt != '0) && (s_q.cnt <= CW'(DELAY)));

endmodule

// File: rtl/hp_event_latch.sv
module hp_event_latch
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_i,
    input  logic             mrl_i,
    input  logic             prsnt_i,
    input  logic             pfault_i,
    input  logic             link_up_i,
    input  logic             cc_done_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [15:0]      status_o
);
    ev_state_t s_q, s_d;
    logic [NFLAG-1:0] set_v;

    always_comb begin
        set_v[0] = btn_i & ~s_q.prev_btn;
        set_v[1] = pfault_i;
        set_v[2] = mrl_i ^ s_q.prev_mrl;
        set_v[3] = prsnt_i ^ s_q.prev_prs;
        set_v[4] = cc_done_i;
        set_v[5] = link_up_i ^ s_q.prev_link;

        s_d           = s_q;
        s_d.prev_btn  = btn_i;
        s_d.prev_mrl  = mrl_i;
        s_d.prev_prs  = prsnt_i;
        s_d.prev_link = link_up_i;
        for (int k = 0; k < NFLAG; k++) begin
            s_d.ev[k] = (s_q.ev[k] & ~clr_i[k]) | set_v[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o  = s_q.ev;
    assign status_o = {7'b0, s_q.ev[5], 1'b0, prsnt_i, mrl_i, s_q.ev[4:0]};

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.ev & $past(s_q.ev & ~clr_i)) == $past(s_q.ev & ~clr_i)));

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pfault_i |=> s_q.ev[1]);

endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
    import hp_slot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl_i,
    input  logic        wr_link_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] ctrl_o,
    output logic        link_dis_o,
    output logic        attn_led_o,
    output logic        attn_blink_o,
    output logic        pwr_led_o,
    output logic        pwr_blink_o,
    output logic        slot_pwr_o
);
    ctrl_state_t s_q, s_d;
    ind_t        attn, pwr;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl_i) s_d.ctrl     = wdata_i & CTRL_WMASK;
        if (wr_link_i) s_d.link_dis = wdata_i[B_LINK_DIS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctrl     <= CTRL_RESET;
            s_q.link_dis <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign attn         = decode_ind(s_q.ctrl[7:6]);
    assign pwr          = decode_ind(s_q.ctrl[9:8]);
    assign ctrl_o       = s_q.ctrl;
    assign link_dis_o   = s_q.link_dis;
    assign attn_led_o   = attn.lit;
    assign attn_blink_o = attn.blink;
    assign pwr_led_o    = pwr.lit;
    assign pwr_blink_o  = pwr.blink;
    assign slot_pwr_o   = ~s_q.ctrl[B_PWR_OFF];

    p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl_i |=> $stable(s_q.ctrl));

endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter int unsigned CC_DELAY      = 125000,
    parameter bit          HAS_PWR_CTRL  = 1'b1,
    parameter bit          HAS_ATTN_IND  = 1'b1,
    parameter bit          HAS_PWR_IND   = 1'b1,
    parameter bit          HAS_INTERLOCK = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        btn_i,
    input  logic        mrl_i,
    input  logic        prsnt_i,
    input  logic        pfault_i,
    input  logic        link_up_i,
    output logic        attn_led_o,
    output logic        attn_blink_o,
    output logic        pwr_led_o,
    output logic        pwr_blink_o,
    output logic        slot_pwr_o,
    output logic        link_dis_o,
    output logic        irq_o
);
    localparam bit CC_REPORT = HAS_PWR_CTRL | HAS_ATTN_IND | HAS_PWR_IND | HAS_INTERLOCK;

    logic             wr_ctrl, wr_stat, wr_link;
    logic [15:0]      ctrl_w, status_w;
    logic [NFLAG-1:0] flags_w, clr_w, en_w;
    logic             cc_done;
    logic             link_dis_w;

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign wr_link = reg_wr && (reg_sel == SEL_LINK);
    assign clr_w   = wr_stat ? {reg_wdata[8], reg_wdata[4:0]} : '0;

    hp_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl_i    (wr_ctrl),
        .wr_link_i    (wr_link),
        .wdata_i      (reg_wdata),
        .ctrl_o       (ctrl_w),
        .link_dis_o   (link_dis_w),
        .attn_led_o   (attn_led_o),
        .attn_blink_o (attn_blink_o),
        .pwr_led_o    (pwr_led_o),
        .pwr_blink_o  (pwr_blink_o),
        .slot_pwr_o   (slot_pwr_o)
    );

    hp_cmd_timer #(.DELAY(CC_DELAY), .ENABLE(CC_REPORT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_ctrl),
        .done_o  (cc_done)
    );

    hp_event_latch u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_i     (btn_i),
        .mrl_i     (mrl_i),
        .prsnt_i   (prsnt_i),
        .pfault_i  (pfault_i),
        .link_up_i (link_up_i),
        .cc_done_i (cc_done),
        .clr_i     (clr_w),
        .flags_o   (flags_w),
        .status_o  (status_w)
    );

    assign en_w       = {ctrl_w[B_LINK_EN], ctrl_w[4:0]};
    assign irq_o      = ctrl_w[B_HPIE] && |(flags_w & en_w);
    assign link_dis_o = link_dis_w;

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_w;
            SEL_STAT: reg_rdata = status_w;
            SEL_LINK: reg_rdata = {2'b00, link_up_i, 8'h00, link_dis_w, 4'h0};
            default:  reg_rdata = 16'h0000;
        endcase
    end

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !reg_wr) |=> irq_o);

    p_no_cc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !CC_REPORT |-> !flags_w[4]);

endmodule

// File: tb/sim_hp_slot_regs.sv
module sim_hp_slot_regs;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] rdata0, rdata1;
    logic btn = 0, mrl = 0, prs = 0, pf = 0, lup = 0;
    logic a_led, a_blk, p_led, p_blk, s_pwr, l_dis, irq;
    logic a1, b1, c1, d1, e1, f1, g1;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hp_slot_regs #(.CC_DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata0),
        .btn_i(btn), .mrl_i(mrl), .prsnt_i(prs), .pfault_i(pf), .link_up_i(lup),
        .attn_led_o(a_led), .attn_blink_o(a_blk), .pwr_led_o(p_led),
        .pwr_blink_o(p_blk), .slot_pwr_o(s_pwr), .link_dis_o(l_dis), .irq_o(irq)
    );

    hp_slot_regs #(.CC_DELAY(D), .HAS_PWR_CTRL(1'b0), .HAS_ATTN_IND(1'b0),
                   .HAS_PWR_IND(1'b0), .HAS_INTERLOCK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1),
        .btn_i(btn), .mrl_i(mrl), .prsnt_i(prs), .pfault_i(pf), .link_up_i(lup),
        .attn_led_o(a1), .attn_blink_o(b1), .pwr_led_o(c1),
        .pwr_blink_o(d1), .slot_pwr_o(e1), .link_dis_o(f1), .irq_o(g1)
    );

    // {control word, attn lit, attn blink, pwr lit, pwr blink, slot power}
    localparam logic [20:0] VEC [9] = '{
        {16'h0040, 5'b10_00_1}, {16'h0080, 5'b11_00_1}, {16'h00C0, 5'b00_00_1},
        {16'h0000, 5'b00_00_1}, {16'h0100, 5'b00_10_1}, {16'h0200, 5'b00_11_1},
        {16'h0300, 5'b00_00_1}, {16'h0740, 5'b10_00_0}, {16'h0680, 5'b11_11_0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d, output logic [15:0] d1);
        reg_sel = sel;
        #1;
        d = rdata0;
        d1 = rdata1;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v, v1;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(2'd0, v, v1); chk("R1 ctrl", v, 16'h07C0);
        rd(2'd1, v, v1); chk("R1 status", v, 16'h0000);
        chk("R1 outputs", {a_led, a_blk, p_led, p_blk, s_pwr, l_dis, irq}, 7'b0);

        // R2 R3 R4 decode table
        for (int i = 0; i < 9; i++) begin
            wr(2'd0, VEC[i][20:5]);
            chk("R2 attn", {a_led, a_blk}, VEC[i][4:3]);
            chk("R3 pwr ind", {p_led, p_blk}, VEC[i][2:1]);
            chk("R4 slot power", s_pwr, VEC[i][0]);
        end
        tick(D + 1);
        wr(2'd1, 16'h011F);

        // R12 reserved bits
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v, v1); chk("R12 reserved", v, 16'h17FF);
        wr(2'd0, 16'h07C0);
        tick(D + 1);
        wr(2'd1, 16'h001F);

        // R8 completion timing
        wr(2'd0, 16'h07C0);
        tick(D - 1);
        rd(2'd1, v, v1); chk("R8 early", v[4], 1'b0);
        tick(1);
        rd(2'd1, v, v1); chk("R8 on time", v[4], 1'b1);
        chk("R11 no report", v1[4], 1'b0);
        wr(2'd1, 16'h0010);
        rd(2'd1, v, v1); chk("R6 clear cc", v[4], 1'b0);
        // R8 restart
        wr(2'd0, 16'h07C0);
        tick(2);
        wr(2'd0, 16'h07C0);
        tick(D - 1);
        rd(2'd1, v, v1); chk("R8 restart early", v[4], 1'b0);
        tick(1);
        rd(2'd1, v, v1); chk("R8 restart on time", v[4], 1'b1);
        wr(2'd1, 16'h001F);

        // R5 events
        btn = 1'b1; tick(1);
        rd(2'd1, v, v1); chk("R5 button", v[0], 1'b1);
        wr(2'd1, 16'h0001); tick(2);
        rd(2'd1, v, v1); chk("R5 held button once", v[0], 1'b0);
        btn = 1'b0;
        mrl = 1'b1; tick(1);
        rd(2'd1, v, v1); chk("R5 mrl flag+live", {v[5], v[2]}, 2'b11);
        prs = 1'b1; tick(1);
        rd(2'd1, v, v1); chk("R5 presence flag+live", {v[6], v[3]}, 2'b11);
        lup = 1'b1; tick(1);
        rd(2'd1, v, v1); chk("R5 link flag", v[8], 1'b1);

        // R6 selective clear, zero write, full clear
        wr(2'd1, 16'h0004);
        rd(2'd1, v, v1); chk("R6 clear one", v & 16'h010F, 16'h0108);
        wr(2'd1, 16'h0000);
        rd(2'd1, v, v1); chk("R6 zero write", v & 16'h010F, 16'h0108);
        wr(2'd1, 16'h011F);
        rd(2'd1, v, v1); chk("R6 full clear", v & 16'h011F, 16'h0000);
        // R6 event coincides with clear
        prs = 1'b0;
        wr(2'd1, 16'h0008);
        rd(2'd1, v, v1); chk("R6 collision kept", v[3], 1'b1);
        wr(2'd1, 16'h0008);

        // R7 sticky fault
        pf = 1'b1; tick(1);
        rd(2'd1, v, v1); chk("R7 fault set", v[1], 1'b1);
        wr(2'd1, 16'h0002);
        rd(2'd1, v, v1); chk("R7 fault resets", v[1], 1'b1);
        pf = 1'b0; tick(1);
        wr(2'd1, 16'h0002);
        rd(2'd1, v, v1); chk("R7 fault clears", v[1], 1'b0);

        // R10 link register
        wr(2'd2, 16'h0010);
        rd(2'd2, v, v1); chk("R10 link reg", {l_dis, v}, {1'b1, 16'h2010});
        wr(2'd2, 16'h0000);
        chk("R10 link enable", l_dis, 1'b0);

        // R9 interrupt gating
        wr(2'd0, 16'h07C8);
        tick(D + 1);
        wr(2'd1, 16'h011F);
        prs = 1'b1; tick(1);
        chk("R9 no global enable", irq, 1'b0);
        wr(2'd0, 16'h07E8);
        chk("R9 level irq", irq, 1'b1);
        tick(3);
        chk("R9 irq holds", irq, 1'b1);
        wr(2'd1, 16'h0008);
        chk("R9 irq drops", irq, 1'b0);
        wr(2'd0, 16'h07F0);
        tick(D - 1);
        chk("R9 cc irq early", irq, 1'b0);
        tick(1);
        chk("R9 cc irq", irq, 1'b1);
        wr(2'd1, 16'h011F);
        wr(2'd0, 16'h17E0);
        lup = 1'b0; tick(1);
        chk("R9 link irq", irq, 1'b1);

        summary();
    end
endmodule